// File: doc/BRIEF.md
# Host Read Intercept and Status Patch Unit

This unit sits on the path between an accelerator processor and a 68000-style asynchronous host bus. Most host cycles go straight through it: the host's data-transfer acknowledge and read data reach the processor without any change. One register address is handled differently. It is the word that holds the peripheral controller's general-purpose input port, and its odd byte sits at byte address 0xFFFA01.

When the processor reads that word, the unit lets the host answer as usual and captures all sixteen data bits. The processor does not see that first host acknowledge, so the read cycle stays open. The unit then turns off the processor-side data buffers and drives its own copy of the word. In that copy, bit 5 (the disk interrupt line, which is active low) is cleared whenever the disk interface's interrupt request is high. Only after the copy is on the bus does the unit give the processor an acknowledge.

The result is that polling firmware sees a pending disk interrupt without any patch wire and without any interrupt-priority signalling. There is no streaming data path here. Every handshake is the bus's own address strobe and acknowledge, and back-pressure is simply the length of the cycle.

Top module: `rd_patch_unit`

## Requirements
- R1: After reset, `cpu_dtack_n` is 1, `cpu_drive_oe` is 0 and `host_buf_oe` is 1.
- R2: During a read (`cpu_rw`=1, `cpu_as_n`=0) whose word address `cpu_addr` (A23..A1) equals 0x7FFD00, a low `host_dtack_n` is not passed on. `cpu_dtack_n` stays 1 until the unit's own acknowledge.
- R3: On the clock edge after the host acknowledge of an intercepted read, `host_buf_oe` goes to 0. `cpu_drive_oe` goes to 1 one edge later. The two enables are never 1 at the same time.
- R4: `cpu_dtack_n` goes low one edge after `cpu_drive_oe` rises. It stays low with `cpu_data` stable until `cpu_as_n` goes high.
- R5: The driven word equals the latched host word, except that bit 5 is forced to 0 when the synchronised `ide_irq` is 1. No other bit changes, including bit 5 when the synchronised `ide_irq` is 0.
- R6: On the first edge at which `cpu_as_n` is seen high, `cpu_drive_oe` returns to 0, `host_buf_oe` returns to 1 and the intercept acknowledge is removed.
- R7: Writes, and reads to any other address, forward `host_dtack_n` to `cpu_dtack_n` and `host_data` to `cpu_data` in the same cycle, with `host_buf_oe`=1 and `cpu_drive_oe`=0.
- R8: `ide_irq` passes through a two-flop synchroniser. A rise that occurs in the same cycle as the host acknowledge is not yet seen when the word is patched, so that word goes out unpatched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Unit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_as_n | input | 1 | Processor address strobe, active low |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_addr | input | 23 | Word address A23..A1 |
| host_dtack_n | input | 1 | Host acknowledge, active low |
| host_data | input | 16 | Read data returned by the host |
| ide_irq | input | 1 | Disk interface interrupt request, asynchronous, active high |
| cpu_dtack_n | output | 1 | Acknowledge seen by the processor, active low |
| cpu_data | output | 16 | Data presented to the processor |
| cpu_drive_oe | output | 1 | Unit drives `cpu_data` onto the processor bus |
| host_buf_oe | output | 1 | Host-to-processor data buffers enabled |

## Verification
The bench targets the first host acknowledge of a hit read. A design that failed to mask it would let the processor finish with unpatched data, and `cpu_dtack_n` would fall in the same cycle as `host_dtack_n`. The bench also checks the hand-over between the buffers and the unit's drivers, where the wrong order would show both enables high, or an acknowledge before the data is driven. Bit patterns in which bit 5 is already clear, and patterns in which every other bit is set, expose a patch that touches the wrong bit or the whole byte. A request that rises in the same cycle as the host acknowledge shows whether the synchroniser really has two stages, because a single-stage version would patch that word.

// File: rtl/rd_patch_pkg.sv
package rd_patch_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_LATCH,
    ST_DRIVE,
    ST_ACK
  } ipu_state_e;
endpackage

// File: rtl/rd_patch_sync.sv
module rd_patch_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rd_patch_match.sv
module rd_patch_match #(
  parameter int                ADDR_W     = 23,
  parameter logic [ADDR_W-1:0] MATCH_WORD = 23'h7FFD00
) (
  input  logic              as_n,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_rd
);
  // A read strobe on the one word that is patched
  assign hit_rd = !as_n && rw && (addr == MATCH_WORD);
endmodule

// File: rtl/rd_patch_fsm.sv
module rd_patch_fsm
  import rd_patch_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       as_n,
  input  logic       hit_rd,
  input  logic       host_dtack_n,
  output ipu_state_e state,
  output logic       latch_en,
  output logic       load_en
);
  ipu_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (hit_rd) nxt = ST_WAIT;
      ST_WAIT:  if (as_n) nxt = ST_IDLE;
                else if (!host_dtack_n) nxt = ST_LATCH;
      ST_LATCH: nxt = as_n ? ST_IDLE : ST_DRIVE;
      ST_DRIVE: nxt = as_n ? ST_IDLE : ST_ACK;
      ST_ACK:   if (as_n) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign latch_en = (state == ST_WAIT)  && !as_n && !host_dtack_n;
  assign load_en  = (state == ST_LATCH) && !as_n;
endmodule

// File: rtl/rd_patch_unit.sv
module rd_patch_unit
  import rd_patch_pkg::*;
#(
  parameter int                ADDR_W      = 23,
  parameter int                DATA_W      = 16,
  parameter logic [ADDR_W-1:0] MATCH_WORD  = 23'h7FFD00,
  parameter int                PATCH_BIT   = 5,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_as_n,
  input  logic              cpu_rw,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              host_dtack_n,
  input  logic [DATA_W-1:0] host_data,
  input  logic              ide_irq,
  output logic              cpu_dtack_n,
  output logic [DATA_W-1:0] cpu_data,
  output logic              cpu_drive_oe,
  output logic              host_buf_oe
);
  localparam int LANE_W = DATA_W / 2;

  ipu_state_e        state;
  logic              hit_rd, latch_en, load_en, irq_s, masking;
  logic [DATA_W-1:0] latched_q, patched_q, patch_word;

  rd_patch_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ide_irq), .q(irq_s)
  );

  rd_patch_match #(.ADDR_W(ADDR_W), .MATCH_WORD(MATCH_WORD)) u_match (
    .as_n(cpu_as_n), .rw(cpu_rw), .addr(cpu_addr), .hit_rd(hit_rd)
  );

  rd_patch_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .as_n(cpu_as_n), .hit_rd(hit_rd),
    .host_dtack_n(host_dtack_n), .state(state),
    .latch_en(latch_en), .load_en(load_en)
  );

  // Only the odd byte lane (low half) is altered; the even lane is copied
  always_comb begin
    patch_word = latched_q;
    for (int i = 0; i < LANE_W; i++) begin
      if (i == PATCH_BIT && irq_s) patch_word[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latched_q <= '0;
      patched_q <= '0;
    end else begin
      if (latch_en) latched_q <= host_data;
      if (load_en)  patched_q <= patch_word;
    end
  end

  assign masking      = (state != ST_IDLE) || hit_rd;
  assign cpu_drive_oe = (state == ST_DRIVE) || (state == ST_ACK);
  assign host_buf_oe  = !((state == ST_LATCH) || cpu_drive_oe);
  assign cpu_dtack_n  = masking ? (state != ST_ACK) : host_dtack_n;
  assign cpu_data     = cpu_drive_oe ? patched_q : host_data;
endmodule

// File: rtl/rd_patch_checker.sv
module rd_patch_checker #(
  parameter int                ADDR_W     = 23,
  parameter int                DATA_W     = 16,
  parameter logic [ADDR_W-1:0] MATCH_WORD = 23'h7FFD00
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_as_n,
  input logic              cpu_rw,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              host_dtack_n,
  input logic [DATA_W-1:0] host_data,
  input logic              cpu_dtack_n,
  input logic [DATA_W-1:0] cpu_data,
  input logic              cpu_drive_oe,
  input logic              host_buf_oe
);
  logic target_rd;
  assign target_rd = !cpu_as_n && cpu_rw && (cpu_addr == MATCH_WORD);

  // R2: first host answer of a target read never reaches the processor
  p_mask_first_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (target_rd && !host_dtack_n && host_buf_oe) |-> cpu_dtack_n);

  // R3: buffers and unit drivers never fight
  p_no_contention_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_drive_oe && host_buf_oe));

  // R4: an acknowledge with buffers off only while driving
  p_ack_while_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_dtack_n && !host_buf_oe) |-> cpu_drive_oe);

  // R4: driven word holds still
  p_data_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_drive_oe && $past(cpu_drive_oe)) |-> $stable(cpu_data));

  // R6: release within one clock of the strobe going inactive
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_drive_oe && cpu_as_n) |=> !cpu_drive_oe);

  // R7: other cycles forward the host acknowledge
  p_pass_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_as_n && !target_rd && host_buf_oe) |-> (cpu_dtack_n == host_dtack_n));
endmodule

bind rd_patch_unit rd_patch_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MATCH_WORD(MATCH_WORD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_as_n(cpu_as_n), .cpu_rw(cpu_rw),
  .cpu_addr(cpu_addr), .host_dtack_n(host_dtack_n), .host_data(host_data),
  .cpu_dtack_n(cpu_dtack_n), .cpu_data(cpu_data),
  .cpu_drive_oe(cpu_drive_oe), .host_buf_oe(host_buf_oe)
);

// File: tb/sim_rd_patch_unit.sv
`timescale 1ns/1ps
module sim_rd_patch_unit;
  localparam logic [22:0] HIT = 23'h7FFD00;

  logic        clk = 0, rst_n = 0;
  logic        cpu_as_n = 1, cpu_rw = 1, host_dtack_n = 1, ide_irq = 0;
  logic [22:0] cpu_addr = '0;
  logic [15:0] host_data = '0;
  logic        cpu_dtack_n, cpu_drive_oe, host_buf_oe;
  logic [15:0] cpu_data;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  rd_patch_unit u0 (
    .clk(clk), .rst_n(rst_n), .cpu_as_n(cpu_as_n), .cpu_rw(cpu_rw),
    .cpu_addr(cpu_addr), .host_dtack_n(host_dtack_n), .host_data(host_data),
    .ide_irq(ide_irq), .cpu_dtack_n(cpu_dtack_n), .cpu_data(cpu_data),
    .cpu_drive_oe(cpu_drive_oe), .host_buf_oe(host_buf_oe)
  );

  function automatic logic [15:0] exp_word(input logic [15:0] w, input bit irq);
    exp_word = w;
    if (irq) exp_word[5] = 1'b0;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic intercept(input logic [15:0] hv, input bit irq,
                           input int dly, input bit late_irq);
    logic [15:0] e;
    @(negedge clk);
    ide_irq = late_irq ? 1'b0 : irq;
    repeat (4) @(negedge clk);
    cpu_addr = HIT; cpu_rw = 1; cpu_as_n = 0; host_dtack_n = 1;
    #1 chk("R2", "dtack before host", cpu_dtack_n, 1);
    for (int i = 0; i < dly; i++) begin
      @(negedge clk); #1 chk("R2", "dtack waiting", cpu_dtack_n, 1);
    end
    @(negedge clk);
    host_dtack_n = 0; host_data = hv;
    if (late_irq) ide_irq = 1;
    #1 chk("R2", "host ack masked", cpu_dtack_n, 1);
    e = late_irq ? hv : exp_word(hv, irq);
    @(negedge clk); #1;
    chk("R3", "buffers off", host_buf_oe, 0);
    chk("R3", "not yet driving", cpu_drive_oe, 0);
    chk("R2", "no ack at latch", cpu_dtack_n, 1);
    @(negedge clk); #1;
    chk("R3", "driving", cpu_drive_oe, 1);
    chk("R4", "no ack at first drive", cpu_dtack_n, 1);
    chk(late_irq ? "R8" : "R5", "driven word", cpu_data, e);
    @(negedge clk); #1;
    chk("R4", "ack", cpu_dtack_n, 0);
    chk("R5", "acked word", cpu_data, e);
    @(negedge clk); #1;
    chk("R4", "ack held", cpu_dtack_n, 0);
    @(negedge clk);
    cpu_as_n = 1; host_dtack_n = 1;
    @(posedge clk); #1;
    chk("R6", "drive released", cpu_drive_oe, 0);
    chk("R6", "buffers back", host_buf_oe, 1);
    chk("R6", "ack released", cpu_dtack_n, 1);
    if (late_irq) ide_irq = 0;
  endtask

  task automatic passthru(input logic [22:0] a, input bit rw,
                          input logic [15:0] hv, input int dly);
    @(negedge clk);
    cpu_addr = a; cpu_rw = rw; cpu_as_n = 0; host_dtack_n = 1;
    #1 chk("R7", "buffers on", host_buf_oe, 1);
    chk("R7", "no drive", cpu_drive_oe, 0);
    chk("R7", "dtack idle", cpu_dtack_n, 1);
    for (int i = 0; i < dly; i++) @(negedge clk);
    host_dtack_n = 0; host_data = hv;
    #1 chk("R7", "dtack forwarded", cpu_dtack_n, 0);
    chk("R7", "data forwarded", cpu_data, hv);
    @(negedge clk);
    cpu_as_n = 1; host_dtack_n = 1;
    #1 chk("R7", "dtack release forwarded", cpu_dtack_n, 1);
  endtask

  task automatic report;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "reset dtack", cpu_dtack_n, 1);
    chk("R1", "reset drive", cpu_drive_oe, 0);
    chk("R1", "reset buffers", host_buf_oe, 1);
    rst_n = 1;
    intercept(16'hFFFF, 1, 0, 0);   // R5 only bit 5 cleared
    intercept(16'hFFFF, 0, 2, 0);   // R5 unchanged without request
    intercept(16'h0000, 0, 1, 0);   // R5 bit already clear stays clear
    intercept(16'hA5DF, 1, 3, 0);
    intercept(16'h1234, 1, 0, 1);   // R8 late request not seen
    passthru(HIT, 0, 16'hBEEF, 1);  // R7 write to target
    passthru(23'h7FFD01, 1, 16'hFFFF, 0);
    passthru(23'h780000, 1, 16'h0020, 2);
    for (int n = 0; n < 60; n++) begin
      int kind = $urandom_range(0, 2);
      logic [15:0] hv = 16'($urandom());
      int d = $urandom_range(0, 3);
      logic [22:0] a = 23'($urandom());
      if (a == HIT) a = a ^ 23'h1;
      case (kind)
        0: intercept(hv, 1'($urandom()), d, 0);
        1: passthru(a, 1, hv, d);
        default: passthru(HIT, 0, hv, d);
      endcase
    end
    report();
  end
endmodule